// File: doc/BRIEF.md
# Strobed Serial-to-Parallel Output Expander

This block gives a host eight extra output pins for the cost of four wires: serial data, a shift clock, a strobe and an active-low clear. Each rising edge of the shift clock pushes one data bit into an internal shift register. A separate output latch drives the parallel pins. The strobe level decides what the latch does. With the strobe high, the latch freezes while a new word is shifted in behind it. With the strobe low, the latch tracks the shift register, so dropping the strobe publishes the assembled word.

The active-low clear zeroes the latch and has priority over the strobe. It never disturbs the shift register. The block runs entirely on a fast system clock. All four host wires pass through two-flop synchronisers, and the shift-clock rising edge is found inside the system-clock domain. The system clock must run at least four times faster than the host shift clock.

Top module: `serial_port_expander`

## Requirements
- R1: While `rst_n` is low, and after it is released, `par_o` reads 0 and the shift register holds 0. The shift register can then be observed through the latch with the strobe low and no shift performed.
- R2: Each new bit enters at `par_o[0]` and moves one place toward `par_o[WIDTH-1]` on every shift. After eight shifts, the first bit sent is on `par_o[7]`, so sending a byte most-significant bit first reproduces it on `par_o`.
- R3: While the strobe is high and clear is inactive, `par_o` does not change, even when shifts occur.
- R4: When the strobe goes low with clear inactive, `par_o` takes the current shift-register contents.
- R5: While the strobe is low and clear is inactive, `par_o` follows the shift register after every shift. The latch loads the freshly shifted word in the same system cycle as the shift register, so no stale word appears in between.
- R6: While the clear input is low, `par_o` reads 0 whatever the strobe does. Shifting continues during this time.
- R7: Clear leaves the shift register untouched. If clear is released while the strobe is low, `par_o` shows every bit shifted in, including bits shifted while clear was low.
- R8: Exactly one shift happens per rising edge of the host shift clock. Holding the shift clock high, and its falling edge, cause no shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset, released synchronously; clears shift register and latch |
| ser_data_i | input | 1 | Host serial data, sampled on the shift-clock rising edge |
| ser_clk_i | input | 1 | Host shift clock |
| ser_strobe_i | input | 1 | Host strobe: high holds the latch, low makes it follow the shift register |
| ser_clr_n_i | input | 1 | Host active-low latch clear |
| par_o | output | WIDTH | Parallel outputs; bit 0 is the end nearest the serial input |

## Verification
On every cycle, the assertions check the following. A detected shift-clock rise can never occur in two consecutive cycles. Each shift puts the synchronised data bit into bit 0. The shift register is stable when no shift occurs. The latch holds under a high strobe, reads zero one cycle after clear, and equals the shift register one cycle after any cycle with the strobe low and clear released. Only the bench scenarios show the end-to-end mapping from serial order to pin order across all 256 byte values. They also show that a strobe fall publishes the word, and that bits shifted while clear was low survive its release.

// File: rtl/spx_pkg.sv
package spx_pkg;

  // Default port width and synchroniser depth for the expander.
  localparam int unsigned SPX_WIDTH       = 8;
  localparam int unsigned SPX_SYNC_STAGES = 2;

  // The four host wires, grouped after synchronisation.
  typedef struct packed {
    logic clr_n;
    logic stb;
    logic sclk;
    logic data;
  } spx_host_t;

  localparam int unsigned SPX_HOST_BITS = $bits(spx_host_t);

  // Reset image for the synchronisers: all host lines read low.
  // The clear therefore stays active until real samples arrive.
  localparam spx_host_t SPX_HOST_RST = '{clr_n: 1'b0, stb: 1'b0, sclk: 1'b0, data: 1'b0};

endpackage

// File: rtl/spx_sync.sv
module spx_sync #(
  parameter int unsigned        N      = 4,
  parameter int unsigned        STAGES = 2,
  parameter logic [N-1:0]       RSTVAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);

  localparam int unsigned LAST = STAGES - 1;

  generate
    for (genvar g = 0; g < N; g++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      logic [STAGES-1:0] chain_d;

      always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_i[g]};
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RSTVAL[g]}};
        else        chain_q <= chain_d;
      end

      assign q_o[g] = chain_q[LAST];
    end
  endgenerate

endmodule

// File: rtl/spx_shift.sv
module spx_shift #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_s,
  input  logic             data_s,
  output logic             shift_o,
  output logic [WIDTH-1:0] sr_next_o,
  output logic [WIDTH-1:0] sr_q_o
);

  logic             sclk_prev_q;
  logic             shift_en;
  logic [WIDTH-1:0] sr_q;
  logic [WIDTH-1:0] sr_d;

  // The edge detector compares the current sample with the previous one.
  always_comb begin
    shift_en = sclk_s & ~sclk_prev_q;
  end

  always_comb begin
    sr_d = sr_q;
    if (shift_en) sr_d = {sr_q[WIDTH-2:0], data_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      sr_q        <= '0;
    end else begin
      sclk_prev_q <= sclk_s;
      if (shift_en) sr_q <= sr_d;
    end
  end

  assign shift_o   = shift_en;
  assign sr_next_o = sr_d;
  assign sr_q_o    = sr_q;

  // R8
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> !shift_en);

  // R2
  entry_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> sr_q[0] == $past(data_s));

  // R7
  sr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sr_q));

endmodule

// File: rtl/spx_latch.sv
module spx_latch #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n_s,
  input  logic             stb_s,
  input  logic             shift_i,
  input  logic [WIDTH-1:0] sr_next_i,
  input  logic [WIDTH-1:0] sr_q_i,
  output logic [WIDTH-1:0] latch_o
);

  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] latch_d;
  logic [WIDTH-1:0] follow_val;
  logic             latch_en;

  // When a shift and a transparent latch coincide, take the post-shift word.
  always_comb begin
    follow_val = shift_i ? sr_next_i : sr_q_i;
  end

  always_comb begin
    latch_en = 1'b0;
    latch_d  = latch_q;
    if (!clr_n_s) begin
      latch_en = 1'b1;
      latch_d  = '0;
    end else if (!stb_s) begin
      latch_en = 1'b1;
      latch_d  = follow_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latch_q <= '0;
    else if (latch_en) latch_q <= latch_d;
  end

  assign latch_o = latch_q;

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n_s |=> latch_q == '0);

  // R3
  strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n_s && stb_s) |=> $stable(latch_q));

endmodule

// File: rtl/serial_port_expander.sv
module serial_port_expander #(
  parameter int unsigned WIDTH       = spx_pkg::SPX_WIDTH,
  parameter int unsigned SYNC_STAGES = spx_pkg::SPX_SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_data_i,
  input  logic             ser_clk_i,
  input  logic             ser_strobe_i,
  input  logic             ser_clr_n_i,
  output logic [WIDTH-1:0] par_o
);

  import spx_pkg::*;

  spx_host_t        host_raw;
  spx_host_t        host_s;
  logic             shift;
  logic [WIDTH-1:0] sr_next;
  logic [WIDTH-1:0] sr_q;
  logic [WIDTH-1:0] latch_q;

  always_comb begin
    host_raw.clr_n = ser_clr_n_i;
    host_raw.stb   = ser_strobe_i;
    host_raw.sclk  = ser_clk_i;
    host_raw.data  = ser_data_i;
  end

  spx_sync #(
    .N      (SPX_HOST_BITS),
    .STAGES (SYNC_STAGES),
    .RSTVAL (SPX_HOST_RST)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (host_raw),
    .q_o   (host_s)
  );

  spx_shift #(.WIDTH(WIDTH)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_s    (host_s.sclk),
    .data_s    (host_s.data),
    .shift_o   (shift),
    .sr_next_o (sr_next),
    .sr_q_o    (sr_q)
  );

  spx_latch #(.WIDTH(WIDTH)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_n_s   (host_s.clr_n),
    .stb_s     (host_s.stb),
    .shift_i   (shift),
    .sr_next_i (sr_next),
    .sr_q_i    (sr_q),
    .latch_o   (latch_q)
  );

  assign par_o = latch_q;

  // R5
  follow_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_s.clr_n && !host_s.stb) |=> par_o == sr_q);

endmodule

// File: tb/serial_port_expander_tb.sv
module serial_port_expander_tb;

  logic       clk;
  logic       rst_n;
  logic       ser_data;
  logic       ser_clk;
  logic       ser_stb;
  logic       ser_clr_n;
  logic [7:0] par;

  int   n_checks;
  int   n_errors;
  logic [7:0] exp_sr;
  logic [7:0] exp_lat;

  serial_port_expander u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ser_data_i   (ser_data),
    .ser_clk_i    (ser_clk),
    .ser_strobe_i (ser_stb),
    .ser_clr_n_i  (ser_clr_n),
    .par_o        (par)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_errors++;
      $display("FAIL %s: par_o=%02h expected=%02h", tag, act, expv);
    end
  endtask

  task automatic shift_bit(input logic b);
    ser_data = b;
    tick(2);
    ser_clk = 1'b1;
    tick(6);
    ser_clk = 1'b0;
    tick(4);
    exp_sr = {exp_sr[6:0], b};
    if (ser_clr_n && !ser_stb) exp_lat = exp_sr;
  endtask

  task automatic set_stb(input logic v);
    ser_stb = v;
    tick(6);
    if (ser_clr_n && !v) exp_lat = exp_sr;
  endtask

  task automatic set_clr_n(input logic v);
    ser_clr_n = v;
    tick(6);
    if (!v) exp_lat = '0;
    else if (!ser_stb) exp_lat = exp_sr;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) shift_bit(b[i]);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(3);
    check("R1 during reset", par, 8'h00);
    rst_n = 1'b1;
    tick(6);
    exp_sr  = '0;
    exp_lat = '0;
  endtask

  initial begin
    #(150000 * 20);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: par_o=%02h expected=run complete", par);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    n_checks  = 0;
    n_errors  = 0;
    ser_data  = 1'b0;
    ser_clk   = 1'b0;
    ser_stb   = 1'b1;
    ser_clr_n = 1'b1;
    exp_sr    = '0;
    exp_lat   = '0;
    rst_n     = 1'b0;
    tick(2);

    // R1: reset state, shift register observed through the transparent latch
    do_reset();
    check("R1 after reset strobe high", par, 8'h00);
    set_stb(1'b0);
    check("R1 shift register clear", par, 8'h00);
    set_stb(1'b1);

    // R2 R3 R4: every byte value, loaded with strobe high, then published
    for (int v = 0; v < 256; v++) begin
      logic [7:0] prev;
      prev = exp_lat;
      send_byte(v[7:0]);
      check("R3 latch held while strobe high", par, prev);
      set_stb(1'b0);
      check("R4 strobe fall loads latch", par, exp_lat);
      check("R2 bit order first bit on msb", par, v[7:0]);
      set_stb(1'b1);
    end

    // R5: strobe low, latch follows each shift
    set_stb(1'b0);
    for (int i = 0; i < 12; i++) begin
      shift_bit(((i * 5) % 3) == 0);
      check("R5 latch follows each shift", par, exp_lat);
    end

    // R8: long high level and falling edge give one shift only
    ser_data = 1'b1;
    tick(2);
    ser_clk = 1'b1;
    tick(6);
    exp_sr  = {exp_sr[6:0], 1'b1};
    exp_lat = exp_sr;
    check("R8 one shift on rise", par, exp_lat);
    ser_data = 1'b0;
    tick(40);
    check("R8 no shift while held high", par, exp_lat);
    ser_clk = 1'b0;
    tick(10);
    check("R8 no shift on fall", par, exp_lat);

    // R6 R7: clear zeroes latch only
    set_stb(1'b1);
    send_byte(8'hA5);
    set_clr_n(1'b0);
    check("R6 clear with strobe high", par, 8'h00);
    set_stb(1'b0);
    check("R6 clear overrides strobe low", par, 8'h00);
    shift_bit(1'b0);
    check("R6 clear holds zero during shift", par, 8'h00);
    set_clr_n(1'b1);
    check("R7 shift register kept across clear", par, 8'h4A);
    check("R7 model agreement", par, exp_lat);

    // R1: system reset clears the shift register too
    send_byte(8'h3C);
    check("R5 follow before reset", par, 8'h3C);
    do_reset();
    check("R1 reset clears register and latch", par, 8'h00);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule